// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects several maskable interrupt sources and presents them to a CPU through a single request line. Each source has a programmable 3-bit priority, where 0 is the most urgent and 7 the least. Each source also has its own mask bit. A global priority threshold blocks every level below it.

When the CPU returns an acknowledge strobe, the controller chooses the most urgent eligible source. Ties within a level go to the lower source index. The controller returns that source's vector type one cycle later, moves the source from pending to in-service, and clears its pending latch.

In-service state enforces nesting. While a handler runs, only a source at a strictly more urgent level can raise the request again, and a source can never interrupt its own handler. Software retires a handler by writing the end-of-interrupt command. That command clears the most urgent in-service bit.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` and `vec_valid` are low. Every source has priority 7 and is unmasked, and the global threshold is 7, so any source that is raised afterwards can request.
- R2: With `EDGE_TRIG`=1, a rising edge on `src_irq[i]` latches source i as pending. `irq_req` is high in any cycle in which at least one pending source is eligible.
- R3: Among eligible sources, the one with the numerically smallest priority wins.
- R4: Among eligible sources that share the best level, the lowest source index wins.
- R5: A write to address i (i < NUM_SRC) loads source i's control. Bit 3 of that word is the per-source mask and bits 2:0 are the priority. A masked source never makes `irq_req` high.
- R6: A write to address NUM_SRC loads the global threshold from bits 2:0. A source whose priority is greater than the threshold is blocked, and one equal to it passes.
- R7: When `int_ack` is high in a cycle with `irq_req` high, the next cycle shows `vec_valid` high for one cycle, with `vec_type` = VEC_BASE + winning index. In the same step the winner becomes in-service and its pending latch clears.
- R8: While any source is in service, a pending source is eligible only if its priority is strictly smaller than every in-service priority.
- R9: A source that is in service cannot be granted again until its in-service bit is cleared, whatever its current priority.
- R10: Any write to address NUM_SRC+1 is the end-of-interrupt command. It clears only the in-service bit of the most urgent in-service source, with lower index on a tie.
- R11: An `int_ack` in a cycle with `irq_req` low produces no vector and changes no in-service or pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Interrupt source inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (sources, threshold, end-of-interrupt) |
| cfg_wdata | input | 4 | Write data: bit 3 mask, bits 2:0 priority or threshold |
| int_ack | input | 1 | Acknowledge strobe from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | One-cycle strobe marking `vec_type` valid |
| vec_type | output | VEC_W | Vector type of the granted source |

## Verification
The bound checker watches several rules on every cycle:
- a raised request always has a pending source behind it;
- a vector strobe only follows an acknowledge, carries an in-range type, and never names a source that was already in service;
- a grant adds exactly one in-service bit, and an end-of-interrupt removes exactly one;
- an acknowledge with no request yields no vector.

Which source wins, how ties and thresholds are settled, and which in-service bit the end-of-interrupt picks are shown by the bench's scenarios, compared cycle by cycle against its reference model.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int PRIO_W = 3;
   typedef logic [PRIO_W-1:0] prio_t;
   localparam prio_t PRIO_LOWEST = '1;

   typedef struct packed {
      logic  masked;
      prio_t prio;
   } src_cfg_t;

   localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/nic_src_slot.sv
module nic_src_slot
   import nic_pkg::*;
#(
   parameter bit EDGE_TRIG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     irq_in,
   input  logic     cfg_wr,
   input  src_cfg_t cfg_wdata,
   input  logic     grant,
   output logic     pending,
   output src_cfg_t cfg
);
   logic arm;

   generate
      if (EDGE_TRIG) begin : g_edge
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_in;
         end
         assign arm = irq_in & ~irq_q;
      end else begin : g_level
         assign arm = irq_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= (pending & ~grant) | arm;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.masked <= 1'b0;
         cfg.prio   <= PRIO_LOWEST;
      end else if (cfg_wr) begin
         cfg <= cfg_wdata;
      end
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
   import nic_pkg::*;
#(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]             req,
   input  logic [N-1:0][PRIO_W-1:0] prio,
   output logic [N-1:0]             grant,
   output logic                     any,
   output logic [IDX_W-1:0]         idx,
   output prio_t                    best
);
   always_comb begin
      grant = '0;
      any   = 1'b0;
      idx   = '0;
      best  = PRIO_LOWEST;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!any || prio[i] < best)) begin
            any      = 1'b1;
            best     = prio[i];
            idx      = IDX_W'(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 32,
   parameter bit EDGE_TRIG = 1'b1,
   parameter int ADDR_W    = $clog2(NUM_SRC + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [3:0]         cfg_wdata,
   input  logic               int_ack,
   output logic               irq_req,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec_type
);
   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int ADR_TH   = NUM_SRC;
   localparam int ADR_EOI  = NUM_SRC + 1;
   localparam int FLOOR_W  = PRIO_W + 1;

   generate
      if (NUM_SRC < 1) begin : g_bad_num
         $error("NUM_SRC must be at least 1");
      end
      if ((NUM_SRC + 2) > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for register map");
      end
      if ((VEC_BASE + NUM_SRC) > (1 << VEC_W)) begin : g_bad_vec
         $error("vector types overflow VEC_W");
      end
      if (CFG_W != 4) begin : g_bad_cfg
         $error("control word layout mismatch");
      end
   endgenerate

   logic [NUM_SRC-1:0]             pend_w;
   logic [NUM_SRC-1:0]             masked_w;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
   logic [NUM_SRC-1:0]             isr_q;
   logic [NUM_SRC-1:0]             elig;
   logic [NUM_SRC-1:0]             win_oh;
   logic [NUM_SRC-1:0]             grant;
   logic [NUM_SRC-1:0]             isr_top;
   logic                           win_any;
   logic                           isr_any;
   logic [IDX_W-1:0]               win_idx;
   logic [IDX_W-1:0]               isr_idx;
   prio_t                          win_prio;
   prio_t                          isr_prio;
   prio_t                          thresh_q;
   logic [FLOOR_W-1:0]             floor_lvl;
   logic                           eoi_cmd;
   logic                           take;

   assign eoi_cmd = cfg_we && (cfg_addr == ADDR_W'(ADR_EOI));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         src_cfg_t slot_cfg;
         logic     slot_wr;
         assign slot_wr = cfg_we && (cfg_addr == ADDR_W'(gi));
         nic_src_slot #(.EDGE_TRIG(EDGE_TRIG)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_in    (src_irq[gi]),
            .cfg_wr    (slot_wr),
            .cfg_wdata (src_cfg_t'(cfg_wdata)),
            .grant     (grant[gi]),
            .pending   (pend_w[gi]),
            .cfg       (slot_cfg)
         );
         assign masked_w[gi] = slot_cfg.masked;
         assign prio_w[gi]   = slot_cfg.prio;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         thresh_q <= PRIO_LOWEST;
      else if (cfg_we && cfg_addr == ADDR_W'(ADR_TH))     thresh_q <= cfg_wdata[PRIO_W-1:0];
   end

   nic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_isr_arb (
      .req   (isr_q),
      .prio  (prio_w),
      .grant (isr_top),
      .any   (isr_any),
      .idx   (isr_idx),
      .best  (isr_prio)
   );

   assign floor_lvl = isr_any ? {1'b0, isr_prio} : FLOOR_W'(1 << PRIO_W);

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         elig[i] = pend_w[i] && !masked_w[i] && !isr_q[i]
                   && (prio_w[i] <= thresh_q)
                   && ({1'b0, prio_w[i]} < floor_lvl);
      end
   end

   nic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_win_arb (
      .req   (elig),
      .prio  (prio_w),
      .grant (win_oh),
      .any   (win_any),
      .idx   (win_idx),
      .best  (win_prio)
   );

   assign take    = int_ack && win_any;
   assign grant   = take ? win_oh : '0;
   assign irq_req = win_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~(eoi_cmd ? isr_top : '0)) | grant;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_type  <= '0;
      end else begin
         vec_valid <= take;
         if (take) vec_type <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      end
   end

   logic unused_ok;
   assign unused_ok = ^{isr_idx, win_prio};
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter int NUM_SRC  = 4,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               int_ack,
   input logic               eoi,
   input logic               irq_req,
   input logic               vec_valid,
   input logic [VEC_W-1:0]   vec_type,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] isr
);
   logic [NUM_SRC-1:0] isr_prev;
   int                 vidx;
   logic               vidx_ok;
   logic               vidx_was_isr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_prev <= '0;
      else        isr_prev <= isr;
   end

   always_comb begin
      vidx         = int'(vec_type) - VEC_BASE;
      vidx_ok      = (vidx >= 0) && (vidx < NUM_SRC);
      vidx_was_isr = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (vidx == i) vidx_was_isr = isr_prev[i];
   end

   // R2: request needs a latched pending source behind it
   a_r2_req_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (|pend));

   // R7: vector strobe only one cycle after an acknowledge
   a_r7_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(int_ack));

   // R7: vector type stays within the source range
   a_r7_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> vidx_ok);

   // R7: a grant adds exactly one in-service bit
   a_r7_grant_adds_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && irq_req && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

   // R9: the granted source was not already in service
   a_r9_no_self_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> !vidx_was_isr);

   // R10: end-of-interrupt clears exactly one in-service bit
   a_r10_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (|isr) && !(int_ack && irq_req)) |=> ($countones(isr) == $countones($past(isr)) - 1));

   // R11: acknowledge without request yields no vector
   a_r11_no_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !irq_req) |=> !vec_valid);
endmodule

bind nest_irq_ctrl nic_checker #(
   .NUM_SRC  (NUM_SRC),
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE)
) u_nic_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .int_ack   (int_ack),
   .eoi       (eoi_cmd),
   .irq_req   (irq_req),
   .vec_valid (vec_valid),
   .vec_type  (vec_type),
   .pend      (pend_w),
   .isr       (isr_q)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
   localparam int N    = 4;
   localparam int BASE = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_irq = '0;
   logic         cfg_we = 1'b0;
   logic [2:0]   cfg_addr = '0;
   logic [3:0]   cfg_wdata = '0;
   logic         int_ack = 1'b0;
   logic         irq_req;
   logic         vec_valid;
   logic [7:0]   vec_type;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   string phase  = "R1";

   always #5 clk = ~clk;

   nest_irq_ctrl #(.NUM_SRC(N), .VEC_W(8), .VEC_BASE(BASE)) i_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_ack(int_ack),
      .irq_req(irq_req), .vec_valid(vec_valid), .vec_type(vec_type)
   );

   // reference model state
   int m_prio[N];
   bit m_msk[N];
   bit m_pend[N];
   bit m_isr[N];
   bit m_prev[N];
   int m_thr;
   bit m_vv;
   int m_vec;

   function automatic int m_pick(bit use_isr);
      int best = 99;
      int who  = -1;
      int flr  = 8;
      for (int i = 0; i < N; i++)
         if (m_isr[i] && m_prio[i] < flr) flr = m_prio[i];
      for (int i = 0; i < N; i++) begin
         bit ok;
         if (use_isr) ok = m_isr[i];
         else ok = m_pend[i] && !m_msk[i] && !m_isr[i] && m_prio[i] <= m_thr && m_prio[i] < flr;
         if (ok && m_prio[i] < best) begin
            best = m_prio[i];
            who  = i;
         end
      end
      return who;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_prio[i] = 7; m_msk[i] = 0; m_pend[i] = 0; m_isr[i] = 0; m_prev[i] = 0;
         end
         m_thr = 7; m_vv = 0; m_vec = 0;
      end else begin
         int w, e;
         w = m_pick(1'b0);
         e = m_pick(1'b1);
         m_vv = int_ack && (w >= 0);
         if (m_vv) begin
            m_vec = BASE + w; m_isr[w] = 1; m_pend[w] = 0;
         end
         if (cfg_we) begin
            if (cfg_addr < N) begin
               m_prio[cfg_addr] = cfg_wdata[2:0]; m_msk[cfg_addr] = cfg_wdata[3];
            end else if (cfg_addr == N) m_thr = cfg_wdata[2:0];
            else if (cfg_addr == N + 1 && e >= 0) m_isr[e] = 0;
         end
         for (int i = 0; i < N; i++) begin
            if (src_irq[i] && !m_prev[i]) m_pend[i] = 1;
            m_prev[i] = src_irq[i];
         end
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(irq_req == (m_pick(1'b0) >= 0), {phase, " irq_req model"}, irq_req, m_pick(1'b0) >= 0);
         check(vec_valid == m_vv, {phase, " vec_valid model"}, vec_valid, m_vv);
         if (m_vv) check(vec_type == m_vec, {phase, " vec_type model"}, vec_type, m_vec);
      end
   end

   task automatic pulse(int i);
      @(negedge clk) src_irq[i] = 1'b1;
      @(negedge clk) src_irq[i] = 1'b0;
   endtask

   task automatic wr(int a, int d);
      @(negedge clk) begin cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 4'(d); end
      @(negedge clk) cfg_we = 1'b0;
   endtask

   task automatic eoi();
      wr(N + 1, 0);
   endtask

   task automatic ack(int exp, string tag);
      @(negedge clk) int_ack = 1'b1;
      @(negedge clk) int_ack = 1'b0;
      if (exp < 0) check(vec_valid == 1'b0, tag, vec_valid, 0);
      else check(vec_valid && vec_type == 8'(exp), tag, vec_valid ? int'(vec_type) : -1, exp);
   endtask

   task automatic req_is(bit exp, string tag);
      check(irq_req == exp, tag, irq_req, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(irq_req == 1'b0, "R1 reset irq_req", irq_req, 0);
      check(vec_valid == 1'b0, "R1 reset vec_valid", vec_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      req_is(1'b0, "R1 idle after reset");

      phase = "R2";
      pulse(3);
      req_is(1'b1, "R2 R1 default level passes");
      phase = "R7";
      ack(BASE + 3, "R7 vector of src3");
      req_is(1'b0, "R7 pending cleared");
      eoi();

      phase = "R4";
      pulse(1); pulse(0);
      ack(BASE + 0, "R4 tie goes to src0");
      req_is(1'b0, "R8 same level blocked");
      eoi();
      req_is(1'b1, "R10 src1 released");
      ack(BASE + 1, "R4 src1 next");
      eoi();

      phase = "R3";
      wr(2, 1); wr(3, 3);
      pulse(3); pulse(2);
      ack(BASE + 2, "R3 level1 beats level3");
      eoi();
      ack(BASE + 3, "R3 remaining src3");
      eoi();

      phase = "R5";
      wr(0, 8);
      pulse(0);
      req_is(1'b0, "R5 masked src0");
      wr(0, 0);
      req_is(1'b1, "R5 unmasked src0");
      ack(BASE + 0, "R5 src0 granted");
      eoi();

      phase = "R6";
      wr(N, 2); wr(3, 5);
      pulse(3);
      req_is(1'b0, "R6 level5 above threshold2");
      wr(2, 2);
      pulse(2);
      ack(BASE + 2, "R6 level equal to threshold");
      eoi();
      wr(N, 7);
      req_is(1'b1, "R6 threshold raised");
      ack(BASE + 3, "R6 src3 granted");
      eoi();

      phase = "R8";
      wr(1, 4); wr(2, 4); wr(0, 6); wr(3, 2);
      pulse(1);
      ack(BASE + 1, "R8 src1 in service");
      pulse(2);
      req_is(1'b0, "R8 equal level4 blocked");
      pulse(0);
      req_is(1'b0, "R8 lower level6 blocked");
      pulse(3);
      req_is(1'b1, "R8 level2 nests");
      ack(BASE + 3, "R8 nested src3");
      phase = "R10";
      eoi();
      req_is(1'b0, "R10 only src3 retired");
      eoi();
      req_is(1'b1, "R10 src1 retired");
      ack(BASE + 2, "R3 level4 beats level6");
      eoi();
      ack(BASE + 0, "R3 src0 last");
      eoi();

      phase = "R9";
      pulse(1);
      ack(BASE + 1, "R9 src1 in service");
      wr(1, 0);
      pulse(1);
      req_is(1'b0, "R9 no self preemption");
      eoi();
      req_is(1'b1, "R9 src1 after release");
      ack(BASE + 1, "R9 src1 again");
      eoi();

      phase = "R11";
      ack(-1, "R11 ack without request");
      req_is(1'b0, "R11 still idle");
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule